// File: doc/BRIEF.md
# Timer0 Counter with Shared Prescaler

This block is the 8-bit timer/counter of a small microcontroller. Each clock of `clk` is one instruction cycle. The counting source is either the instruction cycle itself or an external pin. The pin is sampled once per cycle, and either its rising or its falling transition is counted.

An 8-bit prescaler is shared between this timer and an external watchdog counter, and a routing bit gives it to one of them at a time. The one without the prescaler receives its source undivided. The watchdog's base pulses arrive on `wdt_src`, and the block returns the possibly divided pulses on `wdt_tick`.

Every increment bound for the counter passes through a two-stage synchronizer before it changes the counter. A wrap from FFh to 00h raises a sticky overflow flag. A CPU write loads the counter, clears the prescaler and discards any increments still in flight.

Top module: `tmr0_core`

## Requirements
- R1: After reset, `count` is 00h and `ovf_flag` is 0. The prescaler is cleared and the synchronizer holds no pending increment.
- R2: With `src_pin_sel`=0, every cycle is a source event. An event in cycle k reaches the counter through two register stages, so its increment is first visible in `count` in cycle k+3.
- R3: With `src_pin_sel`=1, `ext_pin` is sampled each cycle. With `fall_edge`=0, an event is a 0-to-1 change between the previous sample and the current value. With `fall_edge`=1, an event is a 1-to-0 change. The latency is the same as in R2.
- R4: With `pre_to_wdt`=0, the counter advances once per 2^(`ratio_sel`+1) source events, giving 1:2 for 0 up to 1:256 for 7. The first advance follows the 2^(`ratio_sel`+1)-th event after the prescaler was cleared.
- R5: With `pre_to_wdt`=1, the prescaler counts `wdt_src` pulses. `wdt_tick` is high on every 2^`ratio_sel`-th pulse, which is 1:1 for 0, and the counter receives source events undivided. With `pre_to_wdt`=0, `wdt_tick` equals `wdt_src` in the same cycle.
- R6: A cycle with `wr_en`=1 loads `wr_data` into `count` at the next edge. It also clears the prescaler, drops both synchronizer stages and ignores the source event of that cycle. With an undivided source that counts every cycle, the loaded value is therefore held for three cycles before it advances.
- R7: An increment that takes `count` from FFh to 00h sets `ovf_flag` at the same edge.
- R8: `ovf_flag` stays set until a cycle with `flag_clr`=1 clears it. A wrap in the same cycle as `flag_clr` leaves the flag set.
- R9: A load never sets `ovf_flag`, even a load of FFh, and a load takes priority over an increment arriving in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pin_sel | input | 1 | 0: count instruction cycles, 1: count pin transitions |
| fall_edge | input | 1 | 0: rising pin transition, 1: falling pin transition |
| pre_to_wdt | input | 1 | 0: prescaler on the timer, 1: prescaler on the watchdog |
| ratio_sel | input | 3 | Prescaler ratio select |
| ext_pin | input | 1 | External counting pin |
| wdt_src | input | 1 | Watchdog base pulse, one cycle wide |
| wr_en | input | 1 | Load strobe from the CPU |
| wr_data | input | 8 | Value to load into the counter |
| flag_clr | input | 1 | Clear strobe for the overflow flag |
| count | output | 8 | Counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| wdt_tick | output | 1 | Tick passed on to the watchdog counter |

## Verification
A prescaler holding a wrong count shifts the first advance after a load away from the 2^(n+1)-th event. That error shows in `count` within one prescaler period plus three cycles. On the watchdog side it shows in `wdt_tick` within 2^n `wdt_src` pulses.

A synchronizer stage that is not dropped on a load shows as an advance during the three cycles in which the loaded value must hold. A wrong edge sample shows three cycles after the pin transition, as one increment too many or one too few.

A flag that clears itself, or that loses to a simultaneous clear, is visible at the edge right after the wrap.

// File: rtl/tmr0_pkg.sv
package tmr0_pkg;
    typedef enum logic {SRC_CYCLE = 1'b0, SRC_PIN = 1'b1} tmr0_src_e;
    typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} tmr0_edge_e;
    typedef enum logic {PRE_TIMER = 1'b0, PRE_WDT = 1'b1} tmr0_route_e;
endpackage

// File: rtl/tmr0_src_sel.sv
module tmr0_src_sel
    import tmr0_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ext_pin,
    input  logic src_pin_sel,
    input  logic fall_edge,
    output logic event_o
);
    typedef struct packed {
        logic pin;
    } src_state_t;

    src_state_t st_d, st_q;
    tmr0_src_e  src;
    tmr0_edge_e pol;

    always_comb begin
        src      = tmr0_src_e'(src_pin_sel);
        pol      = tmr0_edge_e'(fall_edge);
        st_d     = st_q;
        st_d.pin = ext_pin;
        if (src == SRC_CYCLE) begin
            event_o = 1'b1;
        end else if (pol == EDGE_RISE) begin
            event_o = ext_pin & ~st_q.pin;
        end else begin
            event_o = ~ext_pin & st_q.pin;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr0_prescale.sv
module tmr0_prescale
    import tmr0_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int PS_W  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            ev_tmr,
    input  logic            wdt_src,
    input  logic            pre_to_wdt,
    input  logic [PS_W-1:0] ratio_sel,
    output logic            tmr_tick,
    output logic            wdt_tick
);
    localparam int MASK_W = PRE_W + 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t  st_d, st_q;
    tmr0_route_e route;
    logic [MASK_W-1:0] span_t, span_w;
    logic [PRE_W-1:0]  mask_t, mask_w;
    logic full_t, full_w, step;

    always_comb begin
        route  = tmr0_route_e'(pre_to_wdt);
        span_t = MASK_W'(1) << (int'(ratio_sel) + 1);
        span_w = MASK_W'(1) << int'(ratio_sel);
        mask_t = PRE_W'(span_t - MASK_W'(1));
        mask_w = PRE_W'(span_w - MASK_W'(1));
        full_t = (st_q.pre & mask_t) == mask_t;
        full_w = (st_q.pre & mask_w) == mask_w;

        if (route == PRE_TIMER) begin
            step     = ev_tmr;
            tmr_tick = ev_tmr & full_t;
            wdt_tick = wdt_src;
        end else begin
            step     = wdt_src;
            tmr_tick = ev_tmr;
            wdt_tick = wdt_src & full_w;
        end

        st_d = st_q;
        if (clr)       st_d.pre = '0;
        else if (step) st_d.pre = st_q.pre + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr0_sync.sv
module tmr0_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
    } sync_state_t;

    sync_state_t st_d, st_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                st_d.pipe = flush ? 1'b0 : din;
            end
        end else begin : g_chain
            always_comb begin
                st_d.pipe = flush ? '0 : {st_q.pipe[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = st_q.pipe[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr0_core.sv
module tmr0_core #(
    parameter int CNT_W       = 8,
    parameter int PRE_W       = 8,
    parameter int PS_W        = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_pin_sel,
    input  logic             fall_edge,
    input  logic             pre_to_wdt,
    input  logic [PS_W-1:0]  ratio_sel,
    input  logic             ext_pin,
    input  logic             wdt_src,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             ovf_flag,
    output logic             wdt_tick
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } core_state_t;

    core_state_t st_d, st_q;
    logic ev_raw, ev_gated, tmr_tick, inc, wrap;

    tmr0_src_sel u_src (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_pin     (ext_pin),
        .src_pin_sel (src_pin_sel),
        .fall_edge   (fall_edge),
        .event_o     (ev_raw)
    );

    assign ev_gated = ev_raw & ~wr_en;

    tmr0_prescale #(.PRE_W(PRE_W), .PS_W(PS_W)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (wr_en),
        .ev_tmr     (ev_gated),
        .wdt_src    (wdt_src),
        .pre_to_wdt (pre_to_wdt),
        .ratio_sel  (ratio_sel),
        .tmr_tick   (tmr_tick),
        .wdt_tick   (wdt_tick)
    );

    tmr0_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (wr_en),
        .din   (tmr_tick),
        .dout  (inc)
    );

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (wr_en) begin
            st_d.cnt = wr_data;
        end else if (inc) begin
            st_d.cnt = st_q.cnt + 1'b1;
            wrap     = (st_q.cnt == '1);
        end
        if (wrap)          st_d.flag = 1'b1;
        else if (flag_clr) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count    = st_q.cnt;
    assign ovf_flag = st_q.flag;
endmodule

// File: rtl/tmr0_core_chk.sv
module tmr0_core_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pre_to_wdt,
    input logic             wdt_src,
    input logic             wr_en,
    input logic [CNT_W-1:0] wr_data,
    input logic             flag_clr,
    input logic [CNT_W-1:0] count,
    input logic             ovf_flag,
    input logic             wdt_tick
);
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (count == $past(count) || count == CNT_W'($past(count) + 1'b1)));

    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> count == $past(wr_data));

    p_hold_after_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && !wr_en) |=> $stable(count));

    p_wrap_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && count == '1) |=> (count == '1 || (count == '0 && ovf_flag)));

    p_flag_rise_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> count == '0);

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr) |=> ovf_flag);

    p_wdt_undivided_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_to_wdt |-> wdt_tick == wdt_src);
endmodule

bind tmr0_core tmr0_core_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pre_to_wdt (pre_to_wdt),
    .wdt_src    (wdt_src),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .flag_clr   (flag_clr),
    .count      (count),
    .ovf_flag   (ovf_flag),
    .wdt_tick   (wdt_tick)
);

// File: tb/tb_tmr0_core.sv
`timescale 1ns/1ps
module tb_tmr0_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_pin_sel = 1'b0, fall_edge = 1'b0, pre_to_wdt = 1'b1;
    logic [2:0] ratio_sel = 3'd0;
    logic       ext_pin = 1'b0, wdt_src = 1'b0, wr_en = 1'b0, flag_clr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] count;
    logic       ovf_flag, wdt_tick;

    int checks = 0;
    int errors = 0;
    string cur_req = "R2";
    int m_pin = 0, m_pre = 0, m_s1 = 0, m_s2 = 0, m_cnt = 0, m_flag = 0;
    int last_wdt = 0;

    always #4 clk = ~clk;

    tmr0_core dut (
        .clk(clk), .rst_n(rst_n), .src_pin_sel(src_pin_sel), .fall_edge(fall_edge),
        .pre_to_wdt(pre_to_wdt), .ratio_sel(ratio_sel), .ext_pin(ext_pin),
        .wdt_src(wdt_src), .wr_en(wr_en), .wr_data(wr_data), .flag_clr(flag_clr),
        .count(count), .ovf_flag(ovf_flag), .wdt_tick(wdt_tick)
    );

    task automatic check(input int act, input int exp, input string req, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_wdt();
        int period = 1 << int'(ratio_sel);
        if (!pre_to_wdt) return int'(wdt_src);
        return (wdt_src && (m_pre % period) == period - 1) ? 1 : 0;
    endfunction

    function automatic int src_event();
        if (!src_pin_sel) return 1;
        if (!fall_edge) return (ext_pin && m_pin == 0) ? 1 : 0;
        return (!ext_pin && m_pin == 1) ? 1 : 0;
    endfunction

    task automatic tick();
        int ev, to_ctr, adv, nxt;
        #1;
        check(int'(wdt_tick), exp_wdt(), "R5", "wdt_tick");
        last_wdt = int'(wdt_tick);
        ev = (src_event() == 1 && !wr_en) ? 1 : 0;
        if (pre_to_wdt) begin
            to_ctr = ev;
            adv = int'(wdt_src);
        end else begin
            to_ctr = (ev == 1 && (m_pre % (2 << int'(ratio_sel))) == (2 << int'(ratio_sel)) - 1) ? 1 : 0;
            adv = ev;
        end
        @(posedge clk);
        nxt = m_cnt;
        if (wr_en) nxt = int'(wr_data);
        else if (m_s2 == 1) begin
            nxt = (m_cnt + 1) % 256;
            if (m_cnt == 255) m_flag = 1;
            else if (flag_clr) m_flag = 0;
        end else if (flag_clr) m_flag = 0;
        if (wr_en && flag_clr) m_flag = 0;
        m_cnt = nxt;
        m_pre = wr_en ? 0 : (m_pre + adv) % 256;
        m_s2 = wr_en ? 0 : m_s1;
        m_s1 = wr_en ? 0 : to_ctr;
        m_pin = int'(ext_pin);
        #1;
        check(int'(count), m_cnt, cur_req, "count");
        check(int'(ovf_flag), m_flag, cur_req, "ovf_flag");
    endtask

    task automatic load(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        tick();
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ticks;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check(int'(count), 0, "R1", "count in reset");
        check(int'(ovf_flag), 0, "R1", "flag in reset");
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        cur_req = "R1";
        tick();
        check(int'(count), 0, "R1", "count first cycle after reset");

        // R6 / R7: undivided cycle counting, hold after load, wrap
        cur_req = "R6";
        pre_to_wdt = 1'b1; src_pin_sel = 1'b0;
        load(8'hFE);
        check(int'(count), 8'hFE, "R6", "loaded value");
        tick(); check(int'(count), 8'hFE, "R6", "hold 2");
        tick(); check(int'(count), 8'hFE, "R6", "hold 3");
        tick(); check(int'(count), 8'hFF, "R2", "first advance");
        cur_req = "R7";
        tick(); check(int'(count), 8'h00, "R7", "wrap value");
        check(int'(ovf_flag), 1, "R7", "flag after wrap");

        // R8 / R9: clear collides with wrap
        cur_req = "R9";
        flag_clr = 1'b1;
        load(8'hFF);
        flag_clr = 1'b0;
        check(int'(ovf_flag), 0, "R9", "load of FF leaves flag clear");
        tick(); tick();
        cur_req = "R8";
        flag_clr = 1'b1;
        tick();
        check(int'(ovf_flag), 1, "R8", "wrap beats clear");
        tick();
        check(int'(ovf_flag), 0, "R8", "clear alone");
        flag_clr = 1'b0;

        // R4: prescaler on timer
        cur_req = "R4";
        pre_to_wdt = 1'b0; ratio_sel = 3'd1;
        load(8'h00);
        repeat (22) tick();
        check(int'(count), 5, "R4", "ratio 1:4 after 22 cycles");
        ratio_sel = 3'd7;
        load(8'h00);
        repeat (257) tick();
        check(int'(count), 0, "R4", "ratio 1:256 before first advance");
        tick();
        check(int'(count), 1, "R4", "ratio 1:256 first advance");

        // R5: prescaler on watchdog
        cur_req = "R5";
        pre_to_wdt = 1'b1; ratio_sel = 3'd3; wdt_src = 1'b1;
        load(8'h10);
        ticks = 0;
        for (int i = 0; i < 64; i++) begin tick(); ticks += last_wdt; end
        check(ticks, 8, "R5", "wdt ticks at 1:8");
        ratio_sel = 3'd0;
        ticks = 0;
        for (int i = 0; i < 10; i++) begin tick(); ticks += last_wdt; end
        check(ticks, 10, "R5", "wdt ticks at 1:1");
        wdt_src = 1'b0;

        // R3: external pin, both polarities
        cur_req = "R3";
        src_pin_sel = 1'b1; fall_edge = 1'b0; ext_pin = 1'b0;
        load(8'h00);
        for (int p = 0; p < 10; p++) begin
            ext_pin = 1'b1; tick(); tick();
            ext_pin = 1'b0; tick(); tick();
        end
        repeat (4) tick();
        check(int'(count), 10, "R3", "rising transitions");
        fall_edge = 1'b1;
        load(8'h00);
        for (int p = 0; p < 7; p++) begin
            ext_pin = 1'b1; tick();
            ext_pin = 1'b0; tick(); tick();
        end
        repeat (4) tick();
        check(int'(count), 7, "R3", "falling transitions");

        // Random mix against the reference model
        cur_req = "R2";
        for (int i = 0; i < 3000; i++) begin
            if (i % 50 == 0) begin
                src_pin_sel = 1'($urandom_range(0, 1));
                fall_edge   = 1'($urandom_range(0, 1));
                pre_to_wdt  = 1'($urandom_range(0, 1));
                ratio_sel   = 3'($urandom_range(0, 2));
                cur_req     = src_pin_sel ? "R3" : (pre_to_wdt ? "R2" : "R4");
            end
            ext_pin  = 1'($urandom_range(0, 1));
            wdt_src  = 1'($urandom_range(0, 1));
            wr_en    = ($urandom_range(0, 19) == 0);
            wr_data  = ($urandom_range(0, 3) == 0) ? 8'hFC : 8'($urandom);
            flag_clr = ($urandom_range(0, 7) == 0);
            tick();
        end
        wr_en = 1'b0; flag_clr = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule